// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block is a synthesizable model of a serial EEPROM target. It has a chip select, a serial clock, a data input and a data output. A fast system clock samples all three inputs, so the serial clock is treated as data and its rising edges are found by edge detection. The model holds 64 words of 16 bits. A frame begins with a start bit, which is the first 1 seen on a rising serial-clock edge while chip select is high. Two opcode bits and a 6-bit word address follow the start bit.

The host can read a word, write a word, erase a word to all ones, fill the whole array with ones, or fill the whole array with one data word. An arm/disarm latch guards every programming command. A programming cycle starts on the falling edge of chip select. It lasts a set number of system clocks, which stands in for the nonvolatile write delay. If chip select is raised while the cycle runs, the data output reports whether the target is still busy or has become ready. The array is a simple dual-port memory with a registered read, so block RAM can be used. The two whole-array commands write one word per system clock while the cycle is busy.

Top module: `sw3_eeprom_target`

## Requirements
- R1: After a synchronous reset, programming is disarmed, no programming cycle is running, and both `do_o` and `do_oe_o` are 0.
- R2: `do_oe_o` follows the synchronized chip select. While chip select is low, `do_o` is 0 and the frame decoder returns to waiting for a start bit.
- R3: While chip select is high and the target is not busy, 0 bits sampled on rising serial-clock edges before the first 1 are ignored. The first 1 is the start bit. It is followed by a 2-bit opcode and a 6-bit address, each sent MSB first.
- R4: Opcode 10 is a read. On the rising edge that carries the last address bit, `do_o` shows a dummy 0. Each of the next 16 rising edges then shows one bit of the addressed word, MSB first. `do_o` changes only after rising edges. A read works whether programming is armed or not.
- R5: Opcode 00 with address bits [5:4] = 11 arms programming, and 00 with [5:4] = 00 disarms it. While programming is disarmed, write, erase and both fill commands leave the array unchanged and start no cycle.
- R6: Opcode 01 is a write. It is followed by 16 data bits, MSB first. The addressed word takes these bits when chip select falls after the last data bit.
- R7: Opcode 11 is an erase. The addressed word becomes FFFF when chip select falls after the last address bit. Other words keep their values.
- R8: Opcode 00 with [5:4] = 10 sets every word to FFFF. Opcode 00 with [5:4] = 01 takes 16 data bits and writes them to every word.
- R9: A programming cycle lasts `PROG_CYCLES` system clocks, and never fewer than the number of words. If chip select is high and no new start bit has been seen, `do_o` reads 0 while the cycle runs and 1 once it has finished.
- R10: Start bits and all following bits that arrive while a cycle runs are ignored.
- R11: If chip select falls before a frame is complete, the frame has no effect, and the next frame is decoded from its own start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, active high, asynchronous to clk |
| sk_i | input | 1 | Serial clock, asynchronous to clk |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out, or busy/ready status |
| do_oe_o | output | 1 | Output enable for do_o (high while selected) |

## Verification
The embedded properties check the following on every cycle:
- the data output stays quiet while its enable is low;
- read data moves only after a serial-clock rising edge;
- no frame is decoded during a programming cycle;
- no cycle starts while programming is disarmed;
- a cycle ends exactly after its set length.

Some behaviour only the bench scenarios can show. These are the array contents after each command, leading zeros before the start bit, the ready/busy readback, frames that are ignored while busy or aborted early, and a read with the latch disarmed. The bench shows these by writing and reading back all 64 words several times and comparing them with patterns it computes itself.

// File: rtl/sw3_pkg.sv
package sw3_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_DATA, ST_READ, ST_ARMED, ST_DONE
  } sw3_state_t;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] EXT_DISARM    = 2'b00;
  localparam logic [1:0] EXT_FILL_DATA = 2'b01;
  localparam logic [1:0] EXT_FILL_ONES = 2'b10;
  localparam logic [1:0] EXT_ARM       = 2'b11;
endpackage

// File: rtl/sw3_pin_sync.sv
module sw3_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic cs_s,
  output logic di_s,
  output logic sk_rise,
  output logic cs_fall
);
  logic [STAGES-1:0] cs_p, sk_p, di_p;
  logic              sk_q, cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p <= '0;
      sk_p <= '0;
      di_p <= '0;
      sk_q <= 1'b0;
      cs_q <= 1'b0;
    end else begin
      cs_p <= {cs_p[STAGES-2:0], cs_i};
      sk_p <= {sk_p[STAGES-2:0], sk_i};
      di_p <= {di_p[STAGES-2:0], di_i};
      sk_q <= sk_p[STAGES-1];
      cs_q <= cs_p[STAGES-1];
    end
  end

  assign cs_s    = cs_p[STAGES-1];
  assign di_s    = di_p[STAGES-1];
  assign sk_rise = sk_p[STAGES-1] & ~sk_q;
  assign cs_fall = cs_q & ~cs_p[STAGES-1];
endmodule

// File: rtl/sw3_word_array.sv
module sw3_word_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sw3_prog_timer.sv
module sw3_prog_timer #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              all_words,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int CYC   = (PROG_CYCLES > WORDS) ? PROG_CYCLES : WORDS;
  localparam int CNT_W = $clog2(CYC + 1);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(CYC - 1);
  localparam logic [CNT_W-1:0] WORDS_C = CNT_W'(WORDS);

  logic [CNT_W-1:0]  cnt;
  logic              all_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      all_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      cnt    <= '0;
      all_q  <= all_words;
      addr_q <= addr;
      data_q <= data;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    we    = busy && (all_q ? (cnt < WORDS_C) : (cnt == '0));
    waddr = all_q ? cnt[ADDR_W-1:0] : addr_q;
    wdata = data_q;
  end

  // R9
  prog_len_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt == LAST) |=> !busy);

  // R9
  prog_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= LAST));
endmodule

// File: rtl/sw3_frame_ctrl.sv
module sw3_frame_ctrl
  import sw3_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              di_s,
  input  logic              sk_rise,
  input  logic              cs_fall,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] raddr,
  output logic              prog_start,
  output logic              prog_all,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              armed_o,
  output logic              do_o,
  output logic              do_oe_o
);
  localparam int HDR_W = 2 + ADDR_W;
  localparam int MAXB  = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam int CW    = $clog2(MAXB);
  localparam logic [CW-1:0] HDR_LAST = CW'(HDR_W - 1);
  localparam logic [CW-1:0] DAT_LAST = CW'(DATA_W - 1);

  sw3_state_t        state_q;
  logic [CW-1:0]     bitcnt;
  logic [HDR_W-1:0]  hdr_q;
  logic [HDR_W-1:0]  hdr_nx;
  logic [DATA_W-1:0] dat_q;
  logic [DATA_W-1:0] sh_q;
  logic [ADDR_W-1:0] addr_q;
  logic              all_q, erase_q, wen_q, stat_q;
  logic [1:0]        lp_q;
  logic [1:0]        op_nx, ext_nx;

  assign hdr_nx = {hdr_q[HDR_W-2:0], di_s};
  assign op_nx  = hdr_nx[HDR_W-1 -: 2];
  assign ext_nx = hdr_nx[ADDR_W-1 -: 2];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      bitcnt  <= '0;
      hdr_q   <= '0;
      dat_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      all_q   <= 1'b0;
      erase_q <= 1'b0;
      wen_q   <= 1'b0;
      stat_q  <= 1'b0;
      lp_q    <= '0;
      do_o    <= 1'b0;
      do_oe_o <= 1'b0;
    end else begin
      do_oe_o <= cs_s;
      lp_q    <= {lp_q[0], 1'b0};
      if (lp_q[1]) sh_q <= rdata;
      if (prog_start) stat_q <= 1'b1;
      if (!cs_s) begin
        state_q <= ST_IDLE;
        bitcnt  <= '0;
        do_o    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            do_o <= stat_q & ~busy_i;
            if (sk_rise && di_s && !busy_i) begin
              state_q <= ST_HDR;
              bitcnt  <= '0;
              stat_q  <= 1'b0;
              do_o    <= 1'b0;
            end
          end
          ST_HDR: begin
            do_o <= 1'b0;
            if (sk_rise) begin
              hdr_q  <= hdr_nx;
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == HDR_LAST) begin
                bitcnt  <= '0;
                addr_q  <= hdr_nx[ADDR_W-1:0];
                all_q   <= 1'b0;
                erase_q <= 1'b0;
                unique case (op_nx)
                  OP_READ: begin
                    state_q <= ST_READ;
                    lp_q    <= 2'b01;
                  end
                  OP_WRITE: state_q <= ST_DATA;
                  OP_ERASE: begin
                    state_q <= ST_ARMED;
                    erase_q <= 1'b1;
                  end
                  default: begin
                    unique case (ext_nx)
                      EXT_ARM: begin
                        wen_q   <= 1'b1;
                        state_q <= ST_DONE;
                      end
                      EXT_DISARM: begin
                        wen_q   <= 1'b0;
                        state_q <= ST_DONE;
                      end
                      EXT_FILL_ONES: begin
                        all_q   <= 1'b1;
                        erase_q <= 1'b1;
                        state_q <= ST_ARMED;
                      end
                      default: begin
                        all_q   <= 1'b1;
                        state_q <= ST_DATA;
                      end
                    endcase
                  end
                endcase
              end
            end
          end
          ST_DATA: begin
            if (sk_rise) begin
              dat_q  <= {dat_q[DATA_W-2:0], di_s};
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == DAT_LAST) state_q <= ST_ARMED;
            end
          end
          ST_READ: begin
            if (sk_rise) begin
              do_o <= sh_q[DATA_W-1];
              sh_q <= {sh_q[DATA_W-2:0], 1'b0};
            end
          end
          ST_ARMED: begin
            if (sk_rise) state_q <= ST_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  assign raddr      = addr_q;
  assign prog_start = cs_fall && (state_q == ST_ARMED) && wen_q;
  assign prog_all   = all_q;
  assign prog_addr  = addr_q;
  assign prog_data  = erase_q ? '1 : dat_q;
  assign armed_o    = wen_q;

  // R2
  oe_low_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !do_oe_o |-> !do_o);

  // R4
  read_moves_on_sk_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_READ && $past(state_q == ST_READ) && !$stable(do_o)) |-> $past(sk_rise));

  // R10
  no_decode_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HDR) |-> !busy_i);
endmodule

// File: rtl/sw3_eeprom_target.sv
module sw3_eeprom_target #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe_o
);
  logic              cs_s, di_s, sk_rise, cs_fall;
  logic              busy, start, all_words, armed, we;
  logic [ADDR_W-1:0] raddr, paddr, waddr;
  logic [DATA_W-1:0] rdata, pdata, wdata;

  sw3_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cs_i(cs_i), .sk_i(sk_i), .di_i(di_i),
    .cs_s(cs_s), .di_s(di_s), .sk_rise(sk_rise), .cs_fall(cs_fall)
  );

  sw3_frame_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .cs_s(cs_s), .di_s(di_s), .sk_rise(sk_rise),
    .cs_fall(cs_fall), .busy_i(busy), .rdata(rdata), .raddr(raddr),
    .prog_start(start), .prog_all(all_words), .prog_addr(paddr),
    .prog_data(pdata), .armed_o(armed), .do_o(do_o), .do_oe_o(do_oe_o)
  );

  sw3_prog_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(start), .all_words(all_words),
    .addr(paddr), .data(pdata), .busy(busy), .we(we),
    .waddr(waddr), .wdata(wdata)
  );

  sw3_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );

  // R5
  start_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(armed));

  // R10
  no_restart_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);
endmodule

// File: tb/test_sw3_eeprom_target.sv
module test_sw3_eeprom_target;
  localparam int PROG  = 200;
  localparam int LIMIT = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic dout, doe;
  int   n_chk = 0, n_fail = 0, cyc = 0;
  bit   done = 0;

  always #5 clk = ~clk;

  sw3_eeprom_target #(.ADDR_W(6), .DATA_W(16), .PROG_CYCLES(PROG)) i_sw3_eeprom_target (
    .clk(clk), .rst(rst), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(dout), .do_oe_o(doe)
  );

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 16'h0409) ^ 16'h5A3C;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sk_bit(input logic b);
    di = b; tick(4); sk = 1'b1; tick(4); sk = 1'b0;
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [5:0] a, input int lead);
    cs = 1'b1; tick(4);
    repeat (lead) sk_bit(1'b0);
    sk_bit(1'b1);
    for (int i = 1; i >= 0; i--) sk_bit(op[i]);
    for (int i = 5; i >= 0; i--) sk_bit(a[i]);
  endtask

  task automatic deselect();
    cs = 1'b0; di = 1'b0; tick(6);
  endtask

  task automatic read_word(input logic [5:0] a, input int lead, input logic [15:0] exp, input string tag);
    logic [15:0] w;
    send_hdr(2'b10, a, lead);
    tick(2);
    check({15'd0, dout}, 16'd0, "R4 dummy bit");
    for (int i = 15; i >= 0; i--) begin
      sk_bit(1'b0); tick(2);
      w[i] = dout;
    end
    check(w, exp, tag);
    deselect();
  endtask

  task automatic prog(input logic [1:0] op, input logic [5:0] a, input bit has_data,
                      input logic [15:0] d, input logic run, input int lead, input string tag);
    send_hdr(op, a, lead);
    if (has_data) for (int i = 15; i >= 0; i--) sk_bit(d[i]);
    deselect();
    cs = 1'b1; tick(14);
    check({15'd0, dout}, 16'd0, {tag, " R9 busy"});
    tick(PROG + 20);
    check({15'd0, dout}, {15'd0, run}, {tag, " R9 ready"});
    deselect();
  endtask

  task automatic ext_cmd(input logic [1:0] code);
    send_hdr(2'b00, {code, 4'b0000}, 0);
    deselect();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(5); rst = 1'b0; tick(3);
    // R1 reset state
    check({14'd0, dout, doe}, 16'd0, "R1 reset outputs");
    cs = 1'b1; tick(6);
    check({14'd0, dout, doe}, 16'd1, "R1 R2 selected, no status");
    cs = 1'b0; tick(6);
    check({15'd0, doe}, 16'd0, "R2 oe low when deselected");

    // R5 programming refused while disarmed after reset
    prog(2'b01, 6'd3, 1, 16'h1234, 1'b0, 0, "R5 write disarmed");

    ext_cmd(2'b11);
    prog(2'b00, 6'b100000, 0, 16'h0, 1'b1, 0, "R8 fill ones");
    for (int a = 0; a < 64; a++) read_word(6'(a), 0, 16'hFFFF, "R8 fill ones readback");

    ext_cmd(2'b00);
    prog(2'b01, 6'd5, 1, 16'h1234, 1'b0, 1, "R5 write after disarm");
    prog(2'b11, 6'd6, 0, 16'h0, 1'b0, 0, "R5 erase after disarm");
    read_word(6'd5, 0, 16'hFFFF, "R5 word 5 untouched");

    ext_cmd(2'b11);
    // R6 R3 write every word with leading zeros before the start bit
    for (int a = 0; a < 64; a++) prog(2'b01, 6'(a), 1, pat(a), 1'b1, a % 3, "R6 write");
    for (int a = 0; a < 64; a++) read_word(6'(a), (a + 1) % 4, pat(a), "R6 R3 R4 readback");

    // R10 frame sent during a programming cycle is ignored
    send_hdr(2'b01, 6'd7, 0);
    for (int i = 15; i >= 0; i--) sk_bit(pat(70)[i]);
    deselect();
    cs = 1'b1; tick(4);
    sk_bit(1'b1); sk_bit(1'b1); sk_bit(1'b1);
    for (int i = 5; i >= 0; i--) sk_bit(1'(7 >> i));
    deselect();
    tick(PROG + 20);
    read_word(6'd7, 0, pat(70), "R10 erase while busy ignored");

    // R7 single erase
    prog(2'b11, 6'd9, 0, 16'h0, 1'b1, 0, "R7 erase");
    read_word(6'd9, 0, 16'hFFFF, "R7 erased word");
    read_word(6'd10, 0, pat(10), "R7 neighbour kept");

    // R11 aborted frames
    send_hdr(2'b01, 6'd11, 0);
    for (int i = 0; i < 8; i++) sk_bit(1'b0);
    deselect();
    tick(PROG + 20);
    read_word(6'd11, 0, pat(11), "R11 short write no effect");
    cs = 1'b1; tick(4);
    sk_bit(1'b1); sk_bit(1'b1); sk_bit(1'b1); sk_bit(1'b0);
    deselect();
    tick(PROG + 20);
    read_word(6'd12, 2, pat(12), "R11 decode after abort");

    // R8 fill with data
    prog(2'b00, 6'b010000, 1, 16'hA5C3, 1'b1, 0, "R8 fill data");
    for (int a = 0; a < 64; a++) read_word(6'(a), 0, 16'hA5C3, "R8 fill data readback");

    // R4 read while disarmed
    ext_cmd(2'b00);
    read_word(6'd20, 0, 16'hA5C3, "R4 read while disarmed");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule